// File: doc/BRIEF.md
# Byte and Packed-Word FIFO Access Port

This block sits between a 32-bit register bus and the byte-wide transmit and receive FIFOs of a serial flash engine. Software pushes outgoing bytes and pulls incoming bytes through data registers. Separate registers handle single bytes and packed four-byte words. A control flag selects the word behaviour. When it is set, one word write queues four bytes and one word read removes four bytes, with the first byte of the line in bits 7:0.

The status register reports the FIFO levels in terms of the active access width. Software polls the receive-empty flag before each read and the transmit-full flag before each write. In word mode these flags guard a whole word and not a single byte. An access that cannot complete has no effect and sets a sticky error flag. An interrupt line combines the low status flags with an enable mask.

The FIFOs and the shifter are simple models. The shifter is a loopback that moves one byte per cycle from the transmit FIFO to the receive FIFO while `xfer_run_i` is high. The bus accepts a request on every cycle and answers one cycle later.

Top module: `fifo_access_port`

## Requirements
- R1: After reset the control flag and interrupt mask are 0, `irq_o` is 0, and status reads 0x098 (transmit-available, receive-empty and ready set).
- R2: A write to the byte transmit register (offset 3) queues bits 7:0 of the write data. A read of the byte receive register (offset 4) returns the oldest byte in bits 7:0 with bits 31:8 zero and removes it.
- R3: With the word flag (control offset 0, bit 0) set, a write to the word transmit register (offset 5) queues four bytes, bits 7:0 first and bits 31:24 last. A read of the word receive register (offset 6) removes four bytes and returns them in the same order.
- R4: With the word flag clear, the word registers are ignored: writes queue nothing, reads return 0 and remove nothing, and no error is flagged.
- R5: Status bit 4 (receive-empty) is set when fewer bytes are held than the active width (1 in byte mode, 4 in word mode). Bit 2 (receive-available) is its inverse.
- R6: Status bit 5 (transmit-full) is set when fewer free slots remain than the active width. Bit 3 (transmit-available) is its inverse.
- R7: A push that does not fit, or a pop with too few bytes held, changes no FIFO and sets sticky status bit 6. Writing 1 to status bit 6 clears it.
- R8: Status bit 0 (transmit-done) is set when the shifter takes the last queued byte. Bit 1 (receive-done) is set when the shifter delivers a byte. Both are sticky and are cleared by writing 1 to them at offset 2.
- R9: Status bit 7 (ready) is set while the transmit FIFO is empty. Status bit 8 mirrors the word flag.
- R10: The enable register (offset 1) reads back its bits 5:0. `irq_o` is high when any of status bits 5:0 is set together with the enable bit at the same position.
- R11: While `xfer_run_i` is high, the shifter moves one byte per cycle from transmit to receive, in order, and stalls while the receive FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register offset in words |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read or write response valid |
| rsp_rdata_o | output | 32 | Read data |
| xfer_run_i | input | 1 | Lets the loopback shifter move bytes |
| irq_o | output | 1 | Masked status interrupt |

## Verification
A request accepted at a rising edge updates FIFOs, flags and the mask at that same edge. Its read data appears on `rsp_rdata_o` from that edge onward, so the bench samples it at the following falling edge. The status value returned reflects the state before the request took effect. Each shifter cycle that `xfer_run_i` spans moves exactly one byte at that edge. The bench therefore counts run cycles exactly and reads status only after the run input has dropped. `irq_o` follows the registered state combinationally and is sampled one falling edge after the mask write.

// File: rtl/fap_pkg.sv
package fap_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_TXB  = 3'd3,
    A_RXB  = 3'd4,
    A_TXW  = 3'd5,
    A_RXW  = 3'd6
  } reg_addr_e;

  localparam int ST_TXDONE = 0;
  localparam int ST_RXDONE = 1;
  localparam int ST_ERR    = 6;
  localparam int ST_W      = 9;
  localparam int IEN_W     = 6;
endpackage

// File: rtl/fap_fifo.sv
// Byte FIFO pushing or popping up to four bytes per cycle; DEPTH must be a power of two >= 4.
module fap_fifo #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       push_n_i,
  input  logic [31:0]      push_data_i,
  input  logic [2:0]       pop_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [31:0]      peek_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + PTR_W'(push_n_i);
      rd_q  <= rd_q + PTR_W'(pop_n_i);
      cnt_q <= cnt_q + CNT_W'(push_n_i) - CNT_W'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < 4; k++) begin
      if (k < int'(push_n_i)) mem_q[wr_q + PTR_W'(k)] <= push_data_i[8*k +: 8];
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_peek
    assign peek_o[8*k +: 8] = mem_q[rd_q + PTR_W'(k)];
  end

  assign cnt_o = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(push_n_i) <= DEPTH - int'(cnt_q) + int'(pop_n_i));
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(cnt_q));
endmodule

// File: rtl/fap_regs.sv
module fap_regs
  import fap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [2:0]       req_addr_i,
  input  logic [31:0]      req_wdata_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [31:0]      rx_peek_i,
  input  logic             eng_move_i,
  output logic [2:0]       tx_push_n_o,
  output logic [2:0]       rx_pop_n_o,
  output logic             irq_o
);
  logic             word_q;
  logic [IEN_W-1:0] ien_q;
  logic             tx_done_q, rx_done_q, err_q;
  logic [ST_W-1:0]  status;
  logic [31:0]      rdata_d;
  logic             err_evt;
  int               need, tx_free, rx_held;
  logic             rx_empty_f, tx_full_f;

  always_comb begin
    need       = word_q ? 4 : 1;
    tx_free    = DEPTH - int'(tx_cnt_i);
    rx_held    = int'(rx_cnt_i);
    rx_empty_f = rx_held < need;
    tx_full_f  = tx_free < need;
    status     = {word_q, (tx_cnt_i == '0), err_q, tx_full_f, rx_empty_f,
                  ~tx_full_f, ~rx_empty_f, rx_done_q, tx_done_q};
  end

  always_comb begin
    tx_push_n_o = 3'd0;
    rx_pop_n_o  = 3'd0;
    err_evt     = 1'b0;
    rdata_d     = '0;
    if (req_valid_i) begin
      if (req_write_i) begin
        unique case (req_addr_i)
          A_TXB: if (tx_free >= 1) tx_push_n_o = 3'd1; else err_evt = 1'b1;
          A_TXW: if (word_q) begin
            if (tx_free >= 4) tx_push_n_o = 3'd4; else err_evt = 1'b1;
          end
          default: ;
        endcase
      end else begin
        unique case (req_addr_i)
          A_CTRL: rdata_d = {31'd0, word_q};
          A_IEN:  rdata_d = {{(32-IEN_W){1'b0}}, ien_q};
          A_STAT: rdata_d = {{(32-ST_W){1'b0}}, status};
          A_RXB:  if (rx_held >= 1) begin
            rx_pop_n_o = 3'd1;
            rdata_d    = {24'd0, rx_peek_i[7:0]};
          end else err_evt = 1'b1;
          A_RXW:  if (word_q) begin
            if (rx_held >= 4) begin
              rx_pop_n_o = 3'd4;
              rdata_d    = rx_peek_i;
            end else err_evt = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  logic stat_wr, tx_drained;
  assign stat_wr    = req_valid_i && req_write_i && (req_addr_i == A_STAT);
  assign tx_drained = eng_move_i && (tx_cnt_i == CNT_W'(1)) && (tx_push_n_o == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= 1'b0;
      ien_q       <= '0;
      tx_done_q   <= 1'b0;
      rx_done_q   <= 1'b0;
      err_q       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (req_valid_i && req_write_i && req_addr_i == A_CTRL) word_q <= req_wdata_i[0];
      if (req_valid_i && req_write_i && req_addr_i == A_IEN)  ien_q  <= req_wdata_i[IEN_W-1:0];
      // write-one-to-clear; a same-cycle set wins
      tx_done_q   <= (tx_done_q & ~(stat_wr & req_wdata_i[ST_TXDONE])) | tx_drained;
      rx_done_q   <= (rx_done_q & ~(stat_wr & req_wdata_i[ST_RXDONE])) | eng_move_i;
      err_q       <= (err_q & ~(stat_wr & req_wdata_i[ST_ERR])) | err_evt;
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rdata_d;
    end
  end

  assign irq_o = |(status[IEN_W-1:0] & ien_q);

  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(req_valid_i));
  p_txdone_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_q) |-> (tx_cnt_i == '0));
  p_word_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_q |-> (tx_push_n_o != 3'd4 && rx_pop_n_o != 3'd4));
endmodule

// File: rtl/fifo_access_port.sv
module fifo_access_port
  import fap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [2:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  input  logic        xfer_run_i,
  output logic        irq_o
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [31:0]      tx_peek, rx_peek;
  logic [2:0]       tx_push_n, rx_pop_n;
  logic             eng_move;

  assign req_ready_o = 1'b1;

  // loopback shifter model: one byte per cycle
  assign eng_move = xfer_run_i && (tx_cnt != '0) && (rx_cnt != CNT_W'(DEPTH));

  fap_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_n_i(tx_push_n), .push_data_i(req_wdata_i),
    .pop_n_i({2'b00, eng_move}),
    .cnt_o(tx_cnt), .peek_o(tx_peek)
  );

  fap_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_n_i({2'b00, eng_move}), .push_data_i({24'd0, tx_peek[7:0]}),
    .pop_n_i(rx_pop_n),
    .cnt_o(rx_cnt), .peek_o(rx_peek)
  );

  fap_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .rx_peek_i(rx_peek),
    .eng_move_i(eng_move),
    .tx_push_n_o(tx_push_n), .rx_pop_n_o(rx_pop_n),
    .irq_o
  );

  p_move_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_move |=> (rx_cnt != '0));
  p_full_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == CNT_W'(DEPTH) && rx_pop_n == 3'd0) |=> $stable(tx_cnt) || tx_cnt > $past(tx_cnt));
endmodule

// File: tb/fifo_access_port_tb.sv
`timescale 1ns/1ps
module fifo_access_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq, run = 1'b0;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_access_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .xfer_run_i(run), .irq_o(irq)
  );

  // op: 0 read and compare, 1 write, 2 run shifter for data cycles
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd2, 32'h0, 32'h098, 8'd1},        // R1 reset status
    '{2'd1, 3'd3, 32'hABCD1255, 32'h0, 8'd2},
    '{2'd0, 3'd2, 32'h0, 32'h018, 8'd9},        // R9 not ready
    '{2'd2, 3'd0, 32'd1, 32'h0, 8'd11},
    '{2'd0, 3'd2, 32'h0, 32'h08F, 8'd8},        // R8 done flags
    '{2'd0, 3'd4, 32'h0, 32'h055, 8'd2},        // R2 byte read
    '{2'd0, 3'd2, 32'h0, 32'h09B, 8'd5},        // R5 empty again
    '{2'd1, 3'd2, 32'h3, 32'h0, 8'd8},
    '{2'd0, 3'd2, 32'h0, 32'h098, 8'd8},        // R8 cleared
    '{2'd0, 3'd6, 32'h0, 32'h0, 8'd4},          // R4 word read ignored
    '{2'd1, 3'd5, 32'h11223344, 32'h0, 8'd4},
    '{2'd0, 3'd2, 32'h0, 32'h098, 8'd4},        // R4 no push, no error
    '{2'd1, 3'd0, 32'h1, 32'h0, 8'd3},
    '{2'd0, 3'd0, 32'h0, 32'h1, 8'd3},          // R3 flag set
    '{2'd0, 3'd2, 32'h0, 32'h198, 8'd9},        // R9 flag mirrored
    '{2'd1, 3'd5, 32'h44332211, 32'h0, 8'd3},
    '{2'd0, 3'd2, 32'h0, 32'h118, 8'd6},        // R6 four free
    '{2'd1, 3'd5, 32'h88776655, 32'h0, 8'd3},
    '{2'd0, 3'd2, 32'h0, 32'h130, 8'd6},        // R6 full
    '{2'd1, 3'd5, 32'h00000099, 32'h0, 8'd7},
    '{2'd0, 3'd2, 32'h0, 32'h170, 8'd7},        // R7 overflow flagged
    '{2'd1, 3'd2, 32'h40, 32'h0, 8'd7},
    '{2'd0, 3'd2, 32'h0, 32'h130, 8'd7},        // R7 error cleared
    '{2'd2, 3'd0, 32'd3, 32'h0, 8'd11},
    '{2'd0, 3'd2, 32'h0, 32'h132, 8'd6},        // R6 R5 word thresholds
    '{2'd1, 3'd0, 32'h0, 32'h0, 8'd5},
    '{2'd0, 3'd2, 32'h0, 32'h00E, 8'd5},        // R5 R6 byte thresholds
    '{2'd1, 3'd0, 32'h1, 32'h0, 8'd5},
    '{2'd2, 3'd0, 32'd5, 32'h0, 8'd11},
    '{2'd0, 3'd2, 32'h0, 32'h18F, 8'd8},        // R8 drained
    '{2'd0, 3'd6, 32'h0, 32'h44332211, 8'd3},   // R3 little-endian
    '{2'd0, 3'd6, 32'h0, 32'h88776655, 8'd3},   // R3
    '{2'd0, 3'd6, 32'h0, 32'h0, 8'd7},          // R7 underflow
    '{2'd0, 3'd2, 32'h0, 32'h1DB, 8'd7}         // R7 error sticky
  };

  logic [31:0] rd;

  task automatic bus(input logic wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    do_reset();
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: begin
          bus(1'b0, VEC[i].addr, 32'h0);
          check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].exp);
        end
        2'd1: bus(1'b1, VEC[i].addr, VEC[i].data);
        default: run_cycles(int'(VEC[i].data));
      endcase
    end

    // R10 interrupt mask
    bus(1'b1, 3'd1, 32'h10);
    @(negedge clk);
    check("R10 irq rx-empty", {31'd0, irq}, 32'h1);
    bus(1'b1, 3'd1, 32'h20);
    @(negedge clk);
    check("R10 irq masked", {31'd0, irq}, 32'h0);
    bus(1'b0, 3'd1, 32'h0);
    check("R10 ien readback", rd, 32'h20);

    // R11 receive-full stall and ordering
    bus(1'b1, 3'd5, 32'hA4A3A2A1);
    bus(1'b1, 3'd5, 32'hB4B3B2B1);
    run_cycles(8);
    bus(1'b1, 3'd5, 32'hC4C3C2C1);
    run_cycles(4);
    bus(1'b0, 3'd2, 32'h0);
    check("R11 stalled ready/avail", rd & 32'h84, 32'h04);
    bus(1'b0, 3'd6, 32'h0);
    check("R11 word A", rd, 32'hA4A3A2A1);
    run_cycles(4);
    bus(1'b0, 3'd6, 32'h0);
    check("R11 word B", rd, 32'hB4B3B2B1);
    bus(1'b0, 3'd6, 32'h0);
    check("R11 word C", rd, 32'hC4C3C2C1);

    // R1 reset after activity
    do_reset();
    bus(1'b0, 3'd0, 32'h0);
    check("R1 ctrl", rd, 32'h0);
    bus(1'b0, 3'd2, 32'h0);
    check("R1 status", rd, 32'h098);
    bus(1'b0, 3'd1, 32'h0);
    check("R1 ien", rd, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule